// File: doc/BRIEF.md
# Instruction Decode Class Dispatcher

This block sits between an instruction byte fetcher and the execution scheduler of an x86-style integer core. Each instruction reaches it as a primary opcode byte, a secondary opcode byte and an addressing byte whose top two bits select the register form (`11b`) or the memory form (`00b`, `01b`, `10b`). It holds up to two instructions in a small in-order window. It sorts each one into the short, long or vector decode class. For short and long instructions it lists the internal operations the instruction expands to. Each operation carries the execution unit that has to run it.

Each clock the block offers either one or two short instructions, a single long instruction or a single vector instruction. Classes never share a cycle. An offer is taken when the downstream ready is high, and the window then refills from a two-lane upstream port. Vector instructions are handed on with an empty operation list, because their expansion lives in a sequencer outside this block. Opcodes outside the supported subset travel as vector instructions with an unsupported flag set.

Top module: `dcd_dispatch`

## Requirements
- R1: While reset is asserted, and for the two clocks after its release, `iss_vld` and `in_take` are 0. Asserting `rst_n` low empties the window at once, without waiting for a clock.
- R2: Addressing byte bits [7:6] = `11b` select the register form, and `00b`, `01b` and `10b` all select the memory form. For opcodes 10h and 11h the class is short (code 0) in register form and long (code 1) in memory form.
- R3: One cycle offers at most two instructions. Two are offered only when both are short (class code 0). A long (1) or vector (2) instruction is always offered alone in slot 0. Slot fields whose `iss_vld` bit is 0 read as zero.
- R4: Instructions leave in program order, and slot 0 always holds the oldest. When the oldest is short and the next one is not short, only the oldest is offered.
- R5: Opcodes 37h and 3Fh, and the pairs D5h 0Ah and D4h 0Ah, are vector class (code 2) with an operation count of 0 and no unsupported flag.
- R6: Opcode 10h gives a single alux operation in register form, and load, alux, store (operation positions 0, 1, 2) in memory form. Opcode 11h gives the same lists with alu in place of alux.
- R7: Opcodes 12h and 13h are short in both forms. Register form gives one alux (12h) or alu (13h) operation. Memory form gives load followed by alux (12h) or alu (13h).
- R8: Opcode 14h is short with a single alux operation, whatever the addressing byte holds.
- R9: Any other opcode, and D4h/D5h with a second byte other than 0Ah, is offered as vector class with no operations and its `iss_unsup` bit set.
- R10: Operation codes are none=0, load=1, store=2, alu=3, alux=4, branch=5, float=6, media=7, load-immediate=8. Each operation's unit tag follows from its type: load→3 (load unit), store→4 (store unit), alu→2 (either integer unit), alux→1 (X integer unit only), branch→5, float→6 (FP unit), media→7 (MMX unit), load-immediate→8 (instruction control), none→0.
- R11: While `out_ready` is 0, no instruction leaves the window and slot 0 keeps its contents. Upstream lanes are taken only into free window entries.
- R12: An upstream lane k is taken (`in_take[k]`) only when lanes 0..k are all valid and at least k+1 window entries are free after this cycle's issue. Lane 0 is always the older of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 2 | Upstream lane valid, lane 0 oldest |
| in_op0 | input | 16 | Primary opcode byte, lane k at [8k+7:8k] |
| in_op1 | input | 16 | Secondary opcode byte, lane k at [8k+7:8k] |
| in_modrm | input | 16 | Addressing byte, lane k at [8k+7:8k] |
| in_take | output | 2 | Lane k accepted this clock |
| out_ready | input | 1 | Downstream accepts the current offer |
| iss_vld | output | 2 | Slot k holds an offered instruction |
| iss_class | output | 4 | Slot k class at [2k+1:2k]: 0 short, 1 long, 2 vector |
| iss_nuops | output | 4 | Slot k operation count at [2k+1:2k] |
| iss_uop | output | 24 | Slot k operation j type at [(3k+j)*4+3:(3k+j)*4] |
| iss_unit | output | 24 | Unit tag, laid out like `iss_uop` |
| iss_unsup | output | 2 | Slot k carries an unsupported opcode |

## Verification
The bench builds the block with the package defaults: a two-entry window, up to three operations per instruction and four-bit operation and unit codes. With these values every issue combination is reachable: a short pair, a short followed by a long or a vector, a long or vector alone, and a full window held while ready is low. The longest memory-form list of three operations fills every operation position. Driving a single upstream lane against a stalling downstream lets pairs form out of instructions that arrived one at a time. Driving both lanes lets the refill rule meet every count of free entries.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam int WIN     = 2;
  localparam int UOP_MAX = 3;
  localparam int CODE_W  = 4;
  localparam int CLS_W   = 2;
  localparam int BYTE_W  = 8;
  localparam int NUOP_W  = $clog2(UOP_MAX + 1);
  localparam int CNT_W   = $clog2(WIN + 1);

  typedef enum logic [CLS_W-1:0] {
    CLS_SHORT  = 2'd0,
    CLS_LONG   = 2'd1,
    CLS_VECTOR = 2'd2
  } cls_e;

  typedef enum logic [CODE_W-1:0] {
    OP_NONE   = 4'd0,
    OP_LOAD   = 4'd1,
    OP_STORE  = 4'd2,
    OP_ALU    = 4'd3,
    OP_ALUX   = 4'd4,
    OP_BRANCH = 4'd5,
    OP_FLOAT  = 4'd6,
    OP_MEDIA  = 4'd7,
    OP_LIMM   = 4'd8
  } uop_e;

  typedef enum logic [CODE_W-1:0] {
    EU_NONE    = 4'd0,
    EU_INT_X   = 4'd1,
    EU_INT_ANY = 4'd2,
    EU_LOAD    = 4'd3,
    EU_STORE   = 4'd4,
    EU_BRANCH  = 4'd5,
    EU_FPU     = 4'd6,
    EU_MMX     = 4'd7,
    EU_CTRL    = 4'd8
  } unit_e;

  typedef struct packed {
    logic [BYTE_W-1:0] op0;
    logic [BYTE_W-1:0] op1;
    logic [BYTE_W-1:0] modrm;
  } insn_t;

  typedef struct packed {
    logic [CLS_W-1:0]                cls;
    logic [NUOP_W-1:0]               nuops;
    logic [UOP_MAX-1:0][CODE_W-1:0]  uops;
    logic                            unsup;
  } dec_t;
endpackage

// File: rtl/dcd_classify.sv
module dcd_classify
  import dcd_pkg::*;
(
  input  insn_t insn,
  output dec_t  dec
);
  logic mem_form;
  logic [CODE_W-1:0] arith;

  always_comb begin
    mem_form = (insn.modrm[7:6] != 2'b11);
    arith    = (insn.op0[0] == 1'b0) ? OP_ALUX : OP_ALU;
    dec      = '0;
    dec.cls  = CLS_VECTOR;
    case (insn.op0)
      8'h37, 8'h3F: begin
        dec.cls = CLS_VECTOR;
      end
      8'hD4, 8'hD5: begin
        dec.unsup = (insn.op1 != 8'h0A);
      end
      8'h10, 8'h11: begin
        if (mem_form) begin
          dec.cls     = CLS_LONG;
          dec.nuops   = NUOP_W'(3);
          dec.uops[0] = OP_LOAD;
          dec.uops[1] = arith;
          dec.uops[2] = OP_STORE;
        end else begin
          dec.cls     = CLS_SHORT;
          dec.nuops   = NUOP_W'(1);
          dec.uops[0] = arith;
        end
      end
      8'h12, 8'h13: begin
        dec.cls = CLS_SHORT;
        if (mem_form) begin
          dec.nuops   = NUOP_W'(2);
          dec.uops[0] = OP_LOAD;
          dec.uops[1] = arith;
        end else begin
          dec.nuops   = NUOP_W'(1);
          dec.uops[0] = arith;
        end
      end
      8'h14: begin
        dec.cls     = CLS_SHORT;
        dec.nuops   = NUOP_W'(1);
        dec.uops[0] = OP_ALUX;
      end
      default: begin
        dec.unsup = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/dcd_route.sv
module dcd_route
  import dcd_pkg::*;
(
  input  logic [CODE_W-1:0] uop,
  output logic [CODE_W-1:0] unit
);
  always_comb begin
    case (uop)
      OP_LOAD:   unit = EU_LOAD;
      OP_STORE:  unit = EU_STORE;
      OP_ALU:    unit = EU_INT_ANY;
      OP_ALUX:   unit = EU_INT_X;
      OP_BRANCH: unit = EU_BRANCH;
      OP_FLOAT:  unit = EU_FPU;
      OP_MEDIA:  unit = EU_MMX;
      OP_LIMM:   unit = EU_CTRL;
      default:   unit = EU_NONE;
    endcase
  end
endmodule

// File: rtl/dcd_select.sv
module dcd_select
  import dcd_pkg::*;
(
  input  logic [CNT_W-1:0] cnt,
  input  logic [CLS_W-1:0] cls_old,
  input  logic [CLS_W-1:0] cls_young,
  output logic [WIN-1:0]   slot_vld
);
  always_comb begin
    slot_vld    = '0;
    slot_vld[0] = (cnt != '0);
    slot_vld[1] = (cnt == CNT_W'(2)) && (cls_old == CLS_SHORT) &&
                  (cls_young == CLS_SHORT);
  end
endmodule

// File: rtl/dcd_window.sv
module dcd_window
  import dcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIN-1:0]     in_vld,
  input  insn_t [WIN-1:0]    lane_insn,
  input  logic [CNT_W-1:0]   pop_n,
  output logic [WIN-1:0]     in_take,
  output insn_t [WIN-1:0]    win_q,
  output logic [CNT_W-1:0]   win_cnt
);
  insn_t [WIN-1:0]  win_d;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] free;
  logic             chain;
  logic             win_en;

  always_comb begin
    remain  = win_cnt - pop_n;
    free    = CNT_W'(WIN) - remain;
    in_take = '0;
    chain   = rst_n;
    for (int l = 0; l < WIN; l++) begin
      chain = chain && in_vld[l];
      if (chain && (free > CNT_W'(l))) in_take[l] = 1'b1;
    end

    win_d = '0;
    for (int i = 0; i < WIN; i++) begin
      if (i + int'(pop_n) < WIN) win_d[i] = win_q[i + int'(pop_n)];
    end
    cnt_d = remain;
    for (int l = 0; l < WIN; l++) begin
      if (in_take[l]) begin
        win_d[int'(remain) + l] = lane_insn[l];
        cnt_d = cnt_d + CNT_W'(1);
      end
    end
    win_en = (pop_n != '0) || (in_take != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= '0;
      win_cnt <= '0;
    end else if (win_en) begin
      win_q   <= win_d;
      win_cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/dcd_dispatch.sv
module dcd_dispatch
  import dcd_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [WIN-1:0]                in_vld,
  input  logic [WIN*BYTE_W-1:0]         in_op0,
  input  logic [WIN*BYTE_W-1:0]         in_op1,
  input  logic [WIN*BYTE_W-1:0]         in_modrm,
  output logic [WIN-1:0]                in_take,
  input  logic                          out_ready,
  output logic [WIN-1:0]                iss_vld,
  output logic [WIN*CLS_W-1:0]          iss_class,
  output logic [WIN*NUOP_W-1:0]         iss_nuops,
  output logic [WIN*UOP_MAX*CODE_W-1:0] iss_uop,
  output logic [WIN*UOP_MAX*CODE_W-1:0] iss_unit,
  output logic [WIN-1:0]                iss_unsup
);
  logic rs_q1, rs_q2;
  logic rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_s_n = rs_q2;

  insn_t [WIN-1:0]  lane_insn;
  insn_t [WIN-1:0]  win_q;
  logic [CNT_W-1:0] win_cnt;
  logic [CNT_W-1:0] pop_n;
  logic [WIN-1:0]   slot_vld;
  dec_t [WIN-1:0]   dec;

  for (genvar l = 0; l < WIN; l++) begin : g_lane
    assign lane_insn[l] = {in_op0[l*BYTE_W +: BYTE_W],
                           in_op1[l*BYTE_W +: BYTE_W],
                           in_modrm[l*BYTE_W +: BYTE_W]};
  end

  dcd_window u_win (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .in_vld    (in_vld),
    .lane_insn (lane_insn),
    .pop_n     (pop_n),
    .in_take   (in_take),
    .win_q     (win_q),
    .win_cnt   (win_cnt)
  );

  for (genvar s = 0; s < WIN; s++) begin : g_dec
    dcd_classify u_cls (
      .insn (win_q[s]),
      .dec  (dec[s])
    );
  end

  dcd_select u_sel (
    .cnt       (win_cnt),
    .cls_old   (dec[0].cls),
    .cls_young (dec[1].cls),
    .slot_vld  (slot_vld)
  );

  always_comb begin
    pop_n = '0;
    for (int s = 0; s < WIN; s++) begin
      if (slot_vld[s] && out_ready) pop_n = pop_n + CNT_W'(1);
    end
  end

  assign iss_vld = slot_vld;

  for (genvar s = 0; s < WIN; s++) begin : g_slot
    assign iss_class[s*CLS_W +: CLS_W]    = slot_vld[s] ? dec[s].cls   : '0;
    assign iss_nuops[s*NUOP_W +: NUOP_W]  = slot_vld[s] ? dec[s].nuops : '0;
    assign iss_unsup[s]                   = slot_vld[s] && dec[s].unsup;
    for (genvar j = 0; j < UOP_MAX; j++) begin : g_uop
      logic [CODE_W-1:0] unit_w;
      dcd_route u_rt (
        .uop  (dec[s].uops[j]),
        .unit (unit_w)
      );
      assign iss_uop[(s*UOP_MAX+j)*CODE_W +: CODE_W]  = slot_vld[s] ? dec[s].uops[j] : '0;
      assign iss_unit[(s*UOP_MAX+j)*CODE_W +: CODE_W] = slot_vld[s] ? unit_w : '0;
    end
  end
endmodule

// File: rtl/dcd_dispatch_chk.sv
module dcd_dispatch_chk
  import dcd_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic [WIN-1:0]                in_vld,
  input logic [WIN-1:0]                in_take,
  input logic                          out_ready,
  input logic [WIN-1:0]                iss_vld,
  input logic [WIN*CLS_W-1:0]          iss_class,
  input logic [WIN*NUOP_W-1:0]         iss_nuops,
  input logic [WIN*UOP_MAX*CODE_W-1:0] iss_uop,
  input logic [WIN*UOP_MAX*CODE_W-1:0] iss_unit,
  input logic [WIN-1:0]                iss_unsup
);
  assert_pair_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld[1] |-> (iss_class[1:0] == CLS_SHORT) && (iss_class[3:2] == CLS_SHORT));

  assert_long_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld[0] && iss_class[1:0] != CLS_SHORT) |-> !iss_vld[1]);

  assert_oldest_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_vld[1] |-> iss_vld[0]);

  assert_vec_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld[0] && iss_class[1:0] == CLS_VECTOR) |-> (iss_nuops[1:0] == '0));

  assert_unsup_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld[0] && iss_unsup[0]) |-> (iss_class[1:0] == CLS_VECTOR));

  assert_hold_on_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld[0] && !out_ready) |=> (iss_vld[0] && $stable(iss_class[1:0]) &&
                                    $stable(iss_uop[UOP_MAX*CODE_W-1:0])));

  assert_take_chain_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_take[1] |-> (in_take[0] && in_vld[1]));

  for (genvar p = 0; p < WIN*UOP_MAX; p++) begin : g_rt
    assert_alux_unit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_uop[p*CODE_W +: CODE_W] == OP_ALUX) |-> (iss_unit[p*CODE_W +: CODE_W] == EU_INT_X));
    assert_load_unit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_uop[p*CODE_W +: CODE_W] == OP_LOAD) |-> (iss_unit[p*CODE_W +: CODE_W] == EU_LOAD));
  end
endmodule

bind dcd_dispatch dcd_dispatch_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_vld    (in_vld),
  .in_take   (in_take),
  .out_ready (out_ready),
  .iss_vld   (iss_vld),
  .iss_class (iss_class),
  .iss_nuops (iss_nuops),
  .iss_uop   (iss_uop),
  .iss_unit  (iss_unit),
  .iss_unsup (iss_unsup)
);

// File: tb/dcd_dispatch_test.sv
`timescale 1ns/1ps
module dcd_dispatch_test;
  logic        clk;
  logic        rst_n;
  logic [1:0]  in_vld;
  logic [15:0] in_op0, in_op1, in_modrm;
  logic [1:0]  in_take;
  logic        out_ready;
  logic [1:0]  iss_vld;
  logic [3:0]  iss_class;
  logic [3:0]  iss_nuops;
  logic [23:0] iss_uop;
  logic [23:0] iss_unit;
  logic [1:0]  iss_unsup;

  int checks = 0;
  int fails  = 0;

  logic [7:0] p_op0 [64];
  logic [7:0] p_op1 [64];
  logic [7:0] p_mrm [64];
  int n_prog;
  int mq[$];

  dcd_dispatch uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op0(in_op0), .in_op1(in_op1),
    .in_modrm(in_modrm), .in_take(in_take), .out_ready(out_ready), .iss_vld(iss_vld),
    .iss_class(iss_class), .iss_nuops(iss_nuops), .iss_uop(iss_uop),
    .iss_unit(iss_unit), .iss_unsup(iss_unsup)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got running exp finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h", req, what, act, exp);
    end
  endtask

  // reference classification: cls 0 short, 1 long, 2 vector; u[3:0] is the first operation
  function automatic void ref_dec(input logic [7:0] a, input logic [7:0] b, input logic [7:0] m,
                                  output int cls, output int n, output logic [11:0] u,
                                  output logic uns);
    logic regf;
    logic [3:0] k;
    regf = (m[7:6] == 2'b11);
    cls = 2; n = 0; u = '0; uns = 1'b0;
    k = (a == 8'h10 || a == 8'h12 || a == 8'h14) ? 4'd4 : 4'd3;
    if (a == 8'h37 || a == 8'h3F) begin
      uns = 1'b0;
    end else if (a == 8'hD4 || a == 8'hD5) begin
      uns = (b != 8'h0A);
    end else if (a == 8'h10 || a == 8'h11) begin
      if (regf) begin cls = 0; n = 1; u = {8'h00, k}; end
      else begin cls = 1; n = 3; u = {4'd2, k, 4'd1}; end
    end else if (a == 8'h12 || a == 8'h13) begin
      cls = 0;
      if (regf) begin n = 1; u = {8'h00, k}; end
      else begin n = 2; u = {4'd0, k, 4'd1}; end
    end else if (a == 8'h14) begin
      cls = 0; n = 1; u = 12'h004;
    end else begin
      uns = 1'b1;
    end
  endfunction

  function automatic logic [3:0] ref_unit(input logic [3:0] t);
    case (t)
      4'd1: return 4'd3;
      4'd2: return 4'd4;
      4'd3: return 4'd2;
      4'd4: return 4'd1;
      4'd5: return 4'd5;
      4'd6: return 4'd6;
      4'd7: return 4'd7;
      4'd8: return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic string ops_req(input logic [7:0] a, input logic [7:0] b);
    if (a == 8'h10 || a == 8'h11) return "R6";
    if (a == 8'h12 || a == 8'h13) return "R7";
    if (a == 8'h14) return "R8";
    if (a == 8'h37 || a == 8'h3F) return "R5";
    if ((a == 8'hD4 || a == 8'hD5) && b == 8'h0A) return "R5";
    return "R9";
  endfunction

  function automatic int cls_of(input int idx);
    int c, n; logic [11:0] u; logic x;
    ref_dec(p_op0[idx], p_op1[idx], p_mrm[idx], c, n, u, x);
    return c;
  endfunction

  task automatic add(input logic [7:0] a, input logic [7:0] b, input logic [7:0] m);
    p_op0[n_prog] = a; p_op1[n_prog] = b; p_mrm[n_prog] = m;
    n_prog++;
  endtask

  task automatic check_slot(input int k, input int idx);
    int c, n; logic [11:0] u; logic x; logic [11:0] eu; string rq, cr;
    ref_dec(p_op0[idx], p_op1[idx], p_mrm[idx], c, n, u, x);
    rq = ops_req(p_op0[idx], p_op1[idx]);
    cr = (p_op0[idx] == 8'h10 || p_op0[idx] == 8'h11) ? "R2" : rq;
    for (int j = 0; j < 3; j++) eu[j*4 +: 4] = ref_unit(u[j*4 +: 4]);
    chk(cr, $sformatf("slot%0d class op %0h", k, p_op0[idx]), iss_class[k*2 +: 2], c);
    chk(rq, $sformatf("slot%0d op count op %0h", k, p_op0[idx]), iss_nuops[k*2 +: 2], n);
    chk(rq, $sformatf("slot%0d op list op %0h", k, p_op0[idx]), iss_uop[k*12 +: 12], u);
    chk("R10", $sformatf("slot%0d unit tags op %0h", k, p_op0[idx]), iss_unit[k*12 +: 12], eu);
    chk("R9", $sformatf("slot%0d unsupported op %0h", k, p_op0[idx]), iss_unsup[k], x);
  endtask

  // drives the program; rmod>0 drops ready every rmod-th cycle, stall holds ready low at start
  task automatic run_prog(input int rmod, input int stall, input bit two_lanes);
    int pi, c, sz, pops, remain, free;
    bit e1, e2, t0, t1;
    pi = 0; c = 0;
    while ((pi < n_prog || mq.size() > 0) && c < 400) begin
      @(negedge clk);
      in_vld = 2'b00;
      if (pi < n_prog) begin
        in_vld[0] = 1'b1;
        in_op0[7:0] = p_op0[pi]; in_op1[7:0] = p_op1[pi]; in_modrm[7:0] = p_mrm[pi];
      end
      if (two_lanes && pi + 1 < n_prog) begin
        in_vld[1] = 1'b1;
        in_op0[15:8] = p_op0[pi+1]; in_op1[15:8] = p_op1[pi+1]; in_modrm[15:8] = p_mrm[pi+1];
      end
      out_ready = (c >= stall) && (rmod == 0 || (c % rmod) != 0);
      #1;
      sz = mq.size();
      e1 = (sz >= 1);
      e2 = (sz == 2) && (cls_of(mq[0]) == 0) && (cls_of(mq[1]) == 0);
      chk("R3", "slot0 valid", iss_vld[0], e1);
      chk((sz == 2 && cls_of(mq[0]) == 0) ? "R4" : "R3", "slot1 valid", iss_vld[1], e2);
      if (e1) check_slot(0, mq[0]);
      if (e2) check_slot(1, mq[1]);
      else chk("R3", "idle slot1 fields", {iss_class[3:2], iss_nuops[3:2], iss_uop[23:12], iss_unsup[1]}, 0);
      pops = out_ready ? (int'(e1) + int'(e2)) : 0;
      remain = sz - pops;
      free = 2 - remain;
      t0 = in_vld[0] && free >= 1;
      t1 = in_vld[0] && in_vld[1] && free >= 2;
      chk(out_ready ? "R12" : "R11", "lane take", in_take, {t1, t0});
      repeat (pops) void'(mq.pop_front());
      if (t0) begin mq.push_back(pi); pi++; end
      if (t1) begin mq.push_back(pi); pi++; end
      c++;
    end
    chk("R3", "program drained", c < 400, 1);
    @(negedge clk);
    in_vld = 2'b00;
    out_ready = 1'b0;
    n_prog = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_vld = 2'b11;
    #1;
    chk("R1", "take in reset", in_take, 0);
    chk("R1", "valid in reset", iss_vld, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    in_vld = 2'b00;
    repeat (3) @(negedge clk);
    mq.delete();
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1", "idle after release", iss_vld, 0);
    in_vld = 2'b11;
    in_op0 = 16'h1414; in_op1 = 16'h0; in_modrm = 16'hC0C0;
    #1;
    chk("R12", "empty window takes both lanes", in_take, 2'b11);
    in_vld = 2'b00;
    #1;
    @(negedge clk);
    chk("R1", "lanes dropped before edge", iss_vld, 0);
  endtask

  task automatic t_reg_short();
    add(8'h10, 8'h00, 8'hC3); add(8'h11, 8'h00, 8'hD8);
    add(8'h12, 8'h00, 8'hC1); add(8'h13, 8'h00, 8'hFF);
    add(8'h14, 8'h00, 8'h00); add(8'h14, 8'h00, 8'h85);
    add(8'h12, 8'h00, 8'h06); add(8'h13, 8'h00, 8'h45);
    run_prog(0, 0, 1'b1);
  endtask

  task automatic t_mem_forms();
    add(8'h14, 8'h00, 8'hC0); add(8'h10, 8'h00, 8'h00);
    add(8'h11, 8'h00, 8'h41); add(8'h12, 8'h00, 8'h80);
    add(8'h10, 8'h00, 8'h84); add(8'h13, 8'h00, 8'h00);
    add(8'h11, 8'h00, 8'hC0); add(8'h11, 8'h00, 8'h9C);
    run_prog(0, 0, 1'b1);
  endtask

  task automatic t_vector();
    add(8'h37, 8'h00, 8'h00); add(8'h12, 8'h00, 8'hC0);
    add(8'hD5, 8'h0A, 8'hC0); add(8'h14, 8'h00, 8'h10);
    add(8'h3F, 8'h55, 8'h80); add(8'hD4, 8'h0A, 8'h00);
    add(8'h13, 8'h00, 8'h40); add(8'h13, 8'h00, 8'hC8);
    run_prog(0, 0, 1'b1);
  endtask

  task automatic t_unsup();
    add(8'h00, 8'h00, 8'hC0); add(8'hD5, 8'h05, 8'hC0);
    add(8'h14, 8'h00, 8'h00); add(8'h15, 8'h00, 8'hC0);
    add(8'hD4, 8'h0B, 8'h00); add(8'hFF, 8'hFF, 8'hFF);
    run_prog(0, 0, 1'b1);
  endtask

  task automatic t_stall();
    add(8'h12, 8'h00, 8'hC0); add(8'h10, 8'h00, 8'h40);
    add(8'h14, 8'h00, 8'h00); add(8'h13, 8'h00, 8'h01);
    add(8'h37, 8'h00, 8'h00); add(8'h11, 8'h00, 8'hC2);
    add(8'h11, 8'h00, 8'hCA); add(8'h12, 8'h00, 8'h80);
    run_prog(3, 6, 1'b1);
  endtask

  task automatic t_single_lane();
    add(8'h14, 8'h00, 8'h00); add(8'h13, 8'h00, 8'hC0);
    add(8'h12, 8'h00, 8'hC5); add(8'h10, 8'h00, 8'h04);
    add(8'h10, 8'h00, 8'hC4); add(8'h14, 8'h00, 8'hC4);
    run_prog(2, 3, 1'b0);
  endtask

  task automatic t_async_reset();
    @(negedge clk);
    out_ready = 1'b0;
    in_vld = 2'b11;
    in_op0 = 16'h1412; in_op1 = 16'h0; in_modrm = 16'hC0C0;
    @(negedge clk);
    in_vld = 2'b00;
    #1;
    chk("R3", "short pair held", iss_vld, 2'b11);
    rst_n = 1'b0;
    #1;
    chk("R1", "async empty", iss_vld, 0);
    in_vld = 2'b11;
    #1;
    chk("R1", "take blocked in reset", in_take, 0);
    in_vld = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "empty after release", iss_vld, 0);
    mq.delete();
  endtask

  initial begin
    rst_n = 1'b0;
    in_vld = 2'b00;
    in_op0 = '0; in_op1 = '0; in_modrm = '0;
    out_ready = 1'b0;
    n_prog = 0;
    t_reset();
    t_reg_short();
    t_mem_forms();
    t_vector();
    t_unsup();
    t_stall();
    t_single_lane();
    t_async_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule